// File: doc/BRIEF.md
# Four-Channel PWM Global Control Front End

This block sits between a simple memory-mapped register bus and the channels of a PWM peripheral. It holds the channel enable state, reports which channels are still running, and keeps a record of which channels have started a new period since software last looked. Enabling and disabling use two separate write-one registers, so one channel can be switched without a read-modify-write of the others.

A disable takes effect on the enable line at once, but the running status bit for that channel stays set while the channel reports that it is still active. Software polls the status bit to learn when the channel has really stopped. The period-start record clears on read, and a new event that lands in the same cycle as that read is kept for the next read.

Accesses that fall inside the channel window are routed to the register set of one channel: the block raises that channel's select, passes the offset inside the window, the write flag and the write data, and returns the channel's read data. The channel counters themselves live outside this block and feed it period-start pulses and an active flag.

Top module: `pwm_gctl`

## Requirements
- R1: A write to offset 0x04 sets the enable of channel n for each bit n of bits 3:0 that is 1; bits that are 0 leave their enable unchanged. The enable shows on `ch_enable` after the clock edge that takes the write.
- R2: A write to offset 0x08 clears the enable of channel n for each bit n of bits 3:0 that is 1; bits that are 0 leave their enable unchanged.
- R3: Reading offset 0x0C returns the running mask in bits 3:0 (0x0F with all four channels on). A running bit sets with its enable and, after a disable, stays set for as long as `ch_active[n]` is 1, clearing on the first clock edge at which the channel is disabled and `ch_active[n]` is 0.
- R4: Bit n of the register at offset 0x1C is set by a one-cycle pulse on `period_start[n]` and stays set; a read returns the gathered bits and clears all of them.
- R5: A `period_start` pulse in the same cycle as a read of offset 0x1C is not returned by that read and is returned by the next one.
- R6: An access at an address A with 0x200 <= A < 0x280 raises only `ch_sel[n]` with n = (A - 0x200) >> 5 during the request cycle, drives `ch_offset` = A[4:0], `ch_write` and `ch_wdata`; a read returns channel n's 32-bit word from `ch_rdata[32n+31:32n]`.
- R7: Reads of offsets 0x04, 0x08 and of any address that is neither a global register nor in the channel window return 0; writes to 0x0C, 0x1C or unmapped addresses change no state, and no access outside the window raises any `ch_sel` bit.
- R8: After reset all enables, running bits and period-start bits are 0.
- R9: `bus_rdata` is updated at the clock edge that takes a read and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| ch_enable | output | 4 | Enable per channel |
| ch_active | input | 4 | Channel reports it is still inside a period |
| period_start | input | 4 | One-cycle pulse when a channel starts a period |
| ch_sel | output | 4 | One-hot channel select for window accesses |
| ch_write | output | 1 | Write flag toward the channels |
| ch_offset | output | 5 | Offset inside the selected channel's window |
| ch_wdata | output | 32 | Write data toward the channels |
| ch_rdata | input | 128 | Read words of all channels, channel 0 lowest |

## Verification
The bench builds the block with its default parameters: four channels, 32-bit data, a 12-bit address, the channel window at 0x200 with a 0x20 stride. With these values every channel window and the first address past the last one (0x280) are reachable, so both the routing of each channel and the window edges are exercised, together with the disable-while-active lag and a period-start event that collides with the clearing read.

// File: rtl/pwm_gctl_pkg.sv
package pwm_gctl_pkg;

    // Global register offsets; software depends on these positions.
    localparam int unsigned OFS_ENA  = 32'h004;
    localparam int unsigned OFS_DIS  = 32'h008;
    localparam int unsigned OFS_STAT = 32'h00C;
    localparam int unsigned OFS_EVT  = 32'h01C;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_ENA,
        ACC_DIS,
        ACC_STAT,
        ACC_EVT,
        ACC_CHAN
    } acc_kind_e;

endpackage

// File: rtl/pwm_gctl_decode.sv
module pwm_gctl_decode
    import pwm_gctl_pkg::*;
#(
    parameter int unsigned NCH       = 4,
    parameter int unsigned AW        = 12,
    parameter int unsigned CH_BASE   = 32'h200,
    parameter int unsigned CH_STRIDE = 32'h20,
    localparam int unsigned SW       = $clog2(CH_STRIDE),
    localparam int unsigned CIW      = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic [AW-1:0]   addr,
    output acc_kind_e       kind,
    output logic [CIW-1:0]  chan_idx,
    output logic [SW-1:0]   offset,
    output logic [NCH-1:0]  sel
);
    localparam int unsigned WIN_SIZE = NCH * CH_STRIDE;

    logic [31:0] addr_w;
    logic [31:0] rel_w;
    logic        in_win;

    assign addr_w = 32'(addr);
    assign rel_w  = addr_w - CH_BASE;
    assign in_win = (addr_w >= CH_BASE) && (rel_w < WIN_SIZE);

    always_comb begin
        kind = ACC_NONE;
        if (in_win)                 kind = ACC_CHAN;
        else if (addr_w == OFS_ENA) kind = ACC_ENA;
        else if (addr_w == OFS_DIS) kind = ACC_DIS;
        else if (addr_w == OFS_STAT) kind = ACC_STAT;
        else if (addr_w == OFS_EVT) kind = ACC_EVT;
    end

    assign chan_idx = CIW'(rel_w >> SW);
    assign offset   = rel_w[SW-1:0];

    for (genvar n = 0; n < NCH; n++) begin : g_sel
        assign sel[n] = req && in_win && (chan_idx == CIW'(n));
    end

    assert_sel_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));
    assert_no_sel_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!req || kind != ACC_CHAN) |-> (sel == '0));

endmodule

// File: rtl/pwm_gctl_chstate.sv
module pwm_gctl_chstate #(
    parameter int unsigned NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ena_wr,
    input  logic           dis_wr,
    input  logic           evt_rd,
    input  logic [NCH-1:0] mask,
    input  logic [NCH-1:0] ch_active,
    input  logic [NCH-1:0] period_start,
    output logic [NCH-1:0] en_q,
    output logic [NCH-1:0] run_q,
    output logic [NCH-1:0] evt_q
);
    typedef struct packed {
        logic [NCH-1:0] en;
        logic [NCH-1:0] run;
        logic [NCH-1:0] evt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ena_wr) st_d.en = st_q.en | mask;
        if (dis_wr) st_d.en = st_q.en & ~mask;
        // Running holds past a disable while the channel is mid-period.
        st_d.run = st_d.en | (st_q.run & ch_active);
        // Fresh events survive a clearing read.
        st_d.evt = (evt_rd ? '0 : st_q.evt) | period_start;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_q  = st_q.en;
    assign run_q = st_q.run;
    assign evt_q = st_q.evt;

    assert_ena_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ena_wr |=> ((en_q & $past(mask)) == $past(mask)));
    assert_dis_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dis_wr |=> ((en_q & $past(mask)) == '0));
    assert_run_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ena_wr |=> ((run_q & ~$past(run_q)) == '0));
    assert_run_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(run_q & ch_active) & ~run_q) == '0));
    assert_evt_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rd |=> (evt_q == $past(period_start)));

endmodule

// File: rtl/pwm_gctl_rdmux.sv
module pwm_gctl_rdmux
    import pwm_gctl_pkg::*;
#(
    parameter int unsigned NCH = 4,
    parameter int unsigned DW  = 32,
    localparam int unsigned CIW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  acc_kind_e         kind,
    input  logic [CIW-1:0]    chan_idx,
    input  logic [NCH-1:0]    run,
    input  logic [NCH-1:0]    evt,
    input  logic [NCH*DW-1:0] ch_rdata,
    output logic [DW-1:0]     rdata_q
);
    typedef struct packed {
        logic [DW-1:0] rdata;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (rd_stb) begin
            unique case (kind)
                ACC_STAT: rd_d.rdata = DW'(run);
                ACC_EVT:  rd_d.rdata = DW'(evt);
                ACC_CHAN: rd_d.rdata = ch_rdata[int'(chan_idx)*DW +: DW];
                default:  rd_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rdata_q = rd_q.rdata;

    assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rdata_q));
    assert_rd_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && (kind == ACC_NONE || kind == ACC_ENA || kind == ACC_DIS))
        |=> (rdata_q == '0));

endmodule

// File: rtl/pwm_gctl.sv
module pwm_gctl
    import pwm_gctl_pkg::*;
#(
    parameter int unsigned NCH       = 4,
    parameter int unsigned AW        = 12,
    parameter int unsigned DW        = 32,
    parameter int unsigned CH_BASE   = 32'h200,
    parameter int unsigned CH_STRIDE = 32'h20,
    localparam int unsigned SW       = $clog2(CH_STRIDE),
    localparam int unsigned CIW      = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_write,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic [NCH-1:0]    ch_enable,
    input  logic [NCH-1:0]    ch_active,
    input  logic [NCH-1:0]    period_start,
    output logic [NCH-1:0]    ch_sel,
    output logic              ch_write,
    output logic [SW-1:0]     ch_offset,
    output logic [DW-1:0]     ch_wdata,
    input  logic [NCH*DW-1:0] ch_rdata
);
    acc_kind_e      kind;
    logic [CIW-1:0] chan_idx;
    logic [NCH-1:0] run, evt;
    logic           ena_wr, dis_wr, evt_rd, rd_stb;

    pwm_gctl_decode #(
        .NCH(NCH), .AW(AW), .CH_BASE(CH_BASE), .CH_STRIDE(CH_STRIDE)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .req(bus_req), .addr(bus_addr),
        .kind(kind), .chan_idx(chan_idx), .offset(ch_offset), .sel(ch_sel)
    );

    assign ena_wr = bus_req &&  bus_write && (kind == ACC_ENA);
    assign dis_wr = bus_req &&  bus_write && (kind == ACC_DIS);
    assign evt_rd = bus_req && !bus_write && (kind == ACC_EVT);
    assign rd_stb = bus_req && !bus_write;

    pwm_gctl_chstate #(.NCH(NCH)) u_st (
        .clk(clk), .rst_n(rst_n),
        .ena_wr(ena_wr), .dis_wr(dis_wr), .evt_rd(evt_rd),
        .mask(bus_wdata[NCH-1:0]),
        .ch_active(ch_active), .period_start(period_start),
        .en_q(ch_enable), .run_q(run), .evt_q(evt)
    );

    pwm_gctl_rdmux #(.NCH(NCH), .DW(DW)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .kind(kind),
        .chan_idx(chan_idx), .run(run), .evt(evt),
        .ch_rdata(ch_rdata), .rdata_q(bus_rdata)
    );

    assign ch_write = bus_write;
    assign ch_wdata = bus_wdata;

    assert_reset_state_R8: assert property (@(posedge clk)
        $rose(rst_n) |-> (ch_enable == '0 && run == '0));

endmodule

// File: tb/sim_pwm_gctl.sv
module sim_pwm_gctl;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_req = 1'b0;
    logic         bus_write = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [3:0]   ch_enable;
    logic [3:0]   ch_active = '0;
    logic [3:0]   period_start = '0;
    logic [3:0]   ch_sel;
    logic         ch_write;
    logic [4:0]   ch_offset;
    logic [31:0]  ch_wdata;
    logic [127:0] ch_rdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    always_comb begin
        for (int n = 0; n < 4; n++) ch_rdata[n*32 +: 32] = 32'hC4A0_0000 + 32'(n) * 32'h111;
    end

    pwm_gctl u0 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ch_enable(ch_enable), .ch_active(ch_active), .period_start(period_start),
        .ch_sel(ch_sel), .ch_write(ch_write), .ch_offset(ch_offset),
        .ch_wdata(ch_wdata), .ch_rdata(ch_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, input logic [3:0] ps, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_write = 1'b0; bus_addr = a; period_start = ps;
        @(negedge clk);
        bus_req = 1'b0; period_start = '0;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R8 enable after reset", 32'(ch_enable), 32'h0);
        bus_rd(12'h00C, 4'h0, d); chk("R8 status after reset", d, 32'h0);
        bus_rd(12'h01C, 4'h0, d); chk("R8 events after reset", d, 32'h0);
    endtask

    task automatic t_enable;
        logic [31:0] d;
        bus_wr(12'h004, 32'h5); chk("R1 enable 0101", 32'(ch_enable), 32'h5);
        bus_wr(12'h004, 32'h2); chk("R1 zero bits keep", 32'(ch_enable), 32'h7);
        bus_rd(12'h00C, 4'h0, d); chk("R3 status follows enable", d, 32'h7);
    endtask

    task automatic t_disable;
        logic [31:0] d;
        ch_active = 4'b0111;
        bus_wr(12'h008, 32'h1); chk("R2 disable ch0", 32'(ch_enable), 32'h6);
        bus_rd(12'h00C, 4'h0, d); chk("R3 status held while active", d, 32'h7);
        @(negedge clk); ch_active = 4'b0110;
        bus_rd(12'h00C, 4'h0, d); chk("R3 status drops when idle", d, 32'h6);
        bus_wr(12'h008, 32'h0); chk("R2 zero bits keep", 32'(ch_enable), 32'h6);
        bus_wr(12'h004, 32'hF);
        bus_rd(12'h00C, 4'h0, d); chk("R3 all on reads 0F", d, 32'hF);
    endtask

    task automatic t_events;
        logic [31:0] d;
        @(negedge clk); period_start = 4'h5;
        @(negedge clk); period_start = 4'h0;
        bus_rd(12'h01C, 4'h0, d); chk("R4 events gathered", d, 32'h5);
        bus_rd(12'h01C, 4'h0, d); chk("R4 cleared by read", d, 32'h0);
        @(negedge clk); period_start = 4'h1;
        @(negedge clk); period_start = 4'h0;
        bus_rd(12'h01C, 4'h2, d); chk("R5 read returns older event", d, 32'h1);
        bus_rd(12'h01C, 4'h0, d); chk("R5 collided event kept", d, 32'h2);
        bus_rd(12'h01C, 4'h0, d); chk("R5 then cleared", d, 32'h0);
    endtask

    task automatic t_window;
        logic [31:0] d;
        @(negedge clk);
        bus_req = 1'b1; bus_write = 1'b1; bus_addr = 12'h270; bus_wdata = 32'hDEAD_BEEF;
        #1;
        chk("R6 write select ch3", 32'(ch_sel), 32'h8);
        chk("R6 write offset", 32'(ch_offset), 32'h10);
        chk("R6 write flag", 32'(ch_write), 32'h1);
        chk("R6 write data", ch_wdata, 32'hDEAD_BEEF);
        @(negedge clk); bus_req = 1'b0; bus_write = 1'b0;
        @(negedge clk);
        bus_req = 1'b1; bus_addr = 12'h22C;
        #1;
        chk("R6 read select ch1", 32'(ch_sel), 32'h2);
        chk("R6 read offset", 32'(ch_offset), 32'h0C);
        @(negedge clk); bus_req = 1'b0;
        chk("R6 read data ch1", bus_rdata, 32'hC4A0_0111);
        bus_wr(12'h0C0, 32'h0);
        chk("R9 rdata holds across write", bus_rdata, 32'hC4A0_0111);
        bus_rd(12'h200, 4'h0, d); chk("R6 first window word ch0", d, 32'hC4A0_0000);
        @(negedge clk);
        bus_req = 1'b1; bus_addr = 12'h280;
        #1; chk("R7 past window no select", 32'(ch_sel), 32'h0);
        @(negedge clk); bus_req = 1'b0;
        chk("R7 past window reads zero", bus_rdata, 32'h0);
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        bus_rd(12'h004, 4'h0, d); chk("R7 enable reg reads zero", d, 32'h0);
        bus_rd(12'h008, 4'h0, d); chk("R7 disable reg reads zero", d, 32'h0);
        bus_rd(12'h1FC, 4'h0, d); chk("R7 unmapped reads zero", d, 32'h0);
        bus_wr(12'h00C, 32'h0);
        bus_wr(12'h010, 32'h0);
        bus_rd(12'h00C, 4'h0, d); chk("R7 status write ignored", d, 32'hF);
        chk("R7 enable untouched", 32'(ch_enable), 32'hF);
        bus_wr(12'h01C, 32'hF);
        bus_rd(12'h01C, 4'h0, d); chk("R7 event write ignored", d, 32'h0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected=<20000", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_enable;
        t_disable;
        t_events;
        t_window;
        t_unmapped;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule